// File: doc/BRIEF.md
# Coprocessor Interrupt Priority Arbiter

This block decides, once per instruction, whether an embedded CPU core has to enter an interrupt, and which one. It watches four interrupt sources: a non-maskable one and three maskable ones. The maskable sources are a timer, a DMA engine and a request raised by the host CPU. When the core signals that the current cycle is the last one of an instruction, the arbiter looks at all four sources. It then emits a one-cycle entry strobe, the entry vector that goes with the winner, a set pulse for the winner's status flag, and a wake pulse that releases a wait-for-interrupt halt.

Each source has an acknowledge latch, and a source can only win while its latch is clear. Software drives these latches through set and release pulses, which come from register writes that are decoded outside this block. Taking the non-maskable source sets its own latch, so it cannot fire again until software releases it. The three maskable sources share a single vector and are only considered while the core's interrupt-disable flag is clear. One source at most wins per decision. Losing sources are left alone and compete again at the next instruction boundary.

Top module: `irq_arbiter`

## Requirements
- R1: When `boundary` was low at a rising edge, `take`, `wake` and `flag_set` are all zero after that edge. A decision is made only on a boundary cycle.
- R2: The non-maskable source has bit 0 of `src_req`. It wins whenever it is requested and its latch is clear, whatever the value of `irq_disable`. It loads `vec` with `nmi_vec` and raises `flag_set` bit 0.
- R3: Taking the non-maskable source sets acknowledge latch 0. After that, a request on bit 0 is not taken again until an `ack_rel` bit 0 pulse clears the latch.
- R4: The maskable sources are `src_req` bits 1 to 3. None of them is taken while `irq_disable` is 1 at the boundary.
- R5: Among the maskable sources, bit 1 (timer) beats bit 2 (DMA), and bit 2 beats bit 3 (host). `flag_set` has one bit per source, in the same positions as `src_req`.
- R6: Each source is blocked while its acknowledge latch is set. An `ack_set` pulse sets the latch and an `ack_rel` pulse clears it, with both acting at the next edge. If both pulses arrive together, set wins. The latch value that counts at a boundary is the one held before that edge.
- R7: When a maskable source is taken, `vec` is loaded with `irq_vec`.
- R8: `flag_set` has at most one bit set. Both `take` and `wake` are high exactly when `flag_set` is nonzero.
- R9: Synchronous reset clears all latches and drives `take`, `wake`, `flag_set` and `vec` to zero.
- R10: `vec` keeps its value across cycles in which no interrupt is taken.
- R11: A request that loses stays pending. It is taken at a later boundary once the higher-priority sources have been dealt with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Last cycle of the current instruction |
| irq_disable | input | 1 | Core interrupt-disable flag |
| src_req | input | 4 | Source requests: 0 non-maskable, 1 timer, 2 DMA, 3 host |
| ack_set | input | 4 | Per-source latch set pulses |
| ack_rel | input | 4 | Per-source latch release pulses |
| nmi_vec | input | 16 | Entry vector for the non-maskable source |
| irq_vec | input | 16 | Shared entry vector for the maskable sources |
| take | output | 1 | Interrupt entry strobe |
| vec | output | 16 | Selected entry vector, held between entries |
| flag_set | output | 4 | One-hot status flag set pulse |
| wake | output | 1 | Releases a wait-for-interrupt halt |

## Verification
Every result comes from a single register stage. The entry strobe, the flag pulse, the wake pulse and the vector reflect the inputs that were present at the preceding rising edge. Latch changes requested by pulses in a cycle only influence the decision at the next edge. The bench applies inputs at the falling edge and computes the expected outputs from its own latch model. It compares them at the following falling edge, which is exactly one edge later. Directed sequences chain boundaries one cycle apart so that both the latch timing and the handling of pending requests are checked.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int NSRC = 4;

    typedef enum logic [1:0] {
        SRC_NMI = 2'd0,
        SRC_TMR = 2'd1,
        SRC_DMA = 2'd2,
        SRC_HST = 2'd3
    } src_e;

    typedef struct packed {
        logic            hit;
        logic            use_nmi;
        logic [NSRC-1:0] grant;
    } decision_t;

    // Non-maskable first, then maskable sources in ascending bit order.
    function automatic decision_t pick(input logic [NSRC-1:0] elig, input logic mask_off);
        decision_t d;
        d = '0;
        if (elig[SRC_NMI]) begin
            d.hit = 1'b1;
            d.use_nmi = 1'b1;
            d.grant[SRC_NMI] = 1'b1;
        end else if (!mask_off) begin
            for (int k = 1; k < NSRC; k++) begin
                if (elig[k] && !d.hit) begin
                    d.hit = 1'b1;
                    d.grant[k] = 1'b1;
                end
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/irq_ack_bank.sv
module irq_ack_bank
    import irq_arb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_p,
    input  logic [NSRC-1:0] rel_p,
    input  logic [NSRC-1:0] entry_set,
    output logic [NSRC-1:0] held
);
    for (genvar g = 0; g < NSRC; g++) begin : g_lat
        always_ff @(posedge clk) begin
            if (rst)
                held[g] <= 1'b0;
            else if (set_p[g] || entry_set[g])
                held[g] <= 1'b1;
            else if (rel_p[g])
                held[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_arb_pkg::*;
(
    input  logic            boundary,
    input  logic            mask_off,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] held,
    output decision_t       dec
);
    logic [NSRC-1:0] elig;

    always_comb begin
        elig = req & ~held;
        dec  = boundary ? pick(elig, mask_off) : '0;
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boundary,
    input  logic             irq_disable,
    input  logic [3:0]       src_req,
    input  logic [3:0]       ack_set,
    input  logic [3:0]       ack_rel,
    input  logic [VEC_W-1:0] nmi_vec,
    input  logic [VEC_W-1:0] irq_vec,
    output logic             take,
    output logic [VEC_W-1:0] vec,
    output logic [3:0]       flag_set,
    output logic             wake
);
    decision_t       dec;
    logic [NSRC-1:0] held;
    logic [NSRC-1:0] entry_set;

    assign entry_set = {{(NSRC-1){1'b0}}, dec.grant[SRC_NMI]};

    irq_ack_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .set_p     (ack_set),
        .rel_p     (ack_rel),
        .entry_set (entry_set),
        .held      (held)
    );

    irq_prio_sel u_sel (
        .boundary (boundary),
        .mask_off (irq_disable),
        .req      (src_req),
        .held     (held),
        .dec      (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take     <= 1'b0;
            wake     <= 1'b0;
            flag_set <= '0;
            vec      <= '0;
        end else begin
            take     <= dec.hit;
            wake     <= dec.hit;
            flag_set <= dec.grant;
            if (dec.hit)
                vec <= dec.use_nmi ? nmi_vec : irq_vec;
        end
    end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int VEC_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             boundary,
    input logic             irq_disable,
    input logic [VEC_W-1:0] nmi_vec,
    input logic [VEC_W-1:0] irq_vec,
    input logic             take,
    input logic [VEC_W-1:0] vec,
    input logic [3:0]       flag_set,
    input logic             wake
);
    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    a_r1_only_at_boundary: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(boundary) |-> (!take && !wake && flag_set == 4'd0));

    a_r8_flag_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flag_set));

    a_r8_take_matches_flags: assert property (@(posedge clk) disable iff (rst)
        (take == (flag_set != 4'd0)) && (wake == take));

    a_r2_nmi_vector: assert property (@(posedge clk) disable iff (rst || !armed)
        flag_set[0] |-> vec == $past(nmi_vec));

    a_r7_irq_vector: assert property (@(posedge clk) disable iff (rst || !armed)
        (flag_set[3:1] != 3'd0) |-> vec == $past(irq_vec));

    a_r4_masked_only_nmi: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(irq_disable) && take) |-> flag_set == 4'b0001);

    a_r10_vec_holds: assert property (@(posedge clk) disable iff (rst || !armed)
        !take |-> $stable(vec));
endmodule

bind irq_arbiter irq_arbiter_chk #(.VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst(rst), .boundary(boundary), .irq_disable(irq_disable),
    .nmi_vec(nmi_vec), .irq_vec(irq_vec), .take(take), .vec(vec),
    .flag_set(flag_set), .wake(wake)
);

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
    logic        clk = 1'b0;
    logic        rst;
    logic        boundary, irq_disable;
    logic [3:0]  src_req, ack_set, ack_rel;
    logic [15:0] nmi_vec, irq_vec;
    logic        take, wake;
    logic [15:0] vec;
    logic [3:0]  flag_set;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic [3:0]  m_lat;
    logic        e_take;
    logic [3:0]  e_flag;
    logic [15:0] e_vec;

    always #10 clk = ~clk;

    irq_arbiter u0 (
        .clk(clk), .rst(rst), .boundary(boundary), .irq_disable(irq_disable),
        .src_req(src_req), .ack_set(ack_set), .ack_rel(ack_rel),
        .nmi_vec(nmi_vec), .irq_vec(irq_vec), .take(take), .vec(vec),
        .flag_set(flag_set), .wake(wake)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [3:0] grant_of(input logic [3:0] req, input logic [3:0] lat,
                                            input logic bnd, input logic dis);
        logic [3:0] el;
        el = req & ~lat;
        if (!bnd) return 4'd0;
        if (el[0]) return 4'b0001;
        if (dis) return 4'd0;
        if (el[1]) return 4'b0010;
        if (el[2]) return 4'b0100;
        if (el[3]) return 4'b1000;
        return 4'd0;
    endfunction

    task automatic step(input logic r, input logic b, input logic d, input logic [3:0] q,
                        input logic [3:0] s, input logic [3:0] l, input string tag);
        logic [3:0] g;
        rst = r; boundary = b; irq_disable = d; src_req = q; ack_set = s; ack_rel = l;
        if (r) begin
            m_lat = 4'd0; e_take = 1'b0; e_flag = 4'd0; e_vec = 16'd0;
        end else begin
            g = grant_of(q, m_lat, b, d);
            e_flag = g;
            e_take = (g != 4'd0);
            if (g[0]) e_vec = nmi_vec;
            else if (g != 4'd0) e_vec = irq_vec;
            for (int k = 0; k < 4; k++)
                m_lat[k] = s[k] | (k == 0 && g[0]) | (m_lat[k] & ~l[k]);
        end
        @(negedge clk);
        tests++;
        if (take !== e_take || wake !== e_take || flag_set !== e_flag || vec !== e_vec) begin
            fails++;
            $display("FAIL %s: take=%b wake=%b flag=%b vec=%h expected take=%b flag=%b vec=%h",
                     tag, take, wake, flag_set, vec, e_take, e_flag, e_vec);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_lat = 4'd0;
        nmi_vec = 16'hA5C3; irq_vec = 16'h1E70;
        rst = 1'b1; boundary = 1'b0; irq_disable = 1'b0;
        src_req = 4'd0; ack_set = 4'd0; ack_rel = 4'd0;
        @(negedge clk);
        // R9: reset with activity present
        step(1, 1, 0, 4'hF, 4'hF, 4'h0, "R9");
        step(1, 1, 0, 4'hF, 4'h0, 4'h0, "R9");
        // R1: no boundary, no decision
        step(0, 0, 0, 4'hF, 4'h0, 4'h0, "R1");
        // R2: non-maskable taken with disable set
        step(0, 1, 1, 4'hF, 4'h0, 4'h0, "R2");
        // R3: latch now blocks; R4: maskables stay masked
        step(0, 1, 1, 4'hF, 4'h0, 4'h0, "R3");
        step(0, 1, 1, 4'hE, 4'h0, 4'h0, "R4");
        // R5 / R7 / R11: order timer, dma, host as each is latched off
        step(0, 1, 0, 4'hF, 4'h2, 4'h0, "R5");
        step(0, 1, 0, 4'hF, 4'h4, 4'h0, "R11");
        step(0, 1, 0, 4'hF, 4'h0, 4'h0, "R7");
        // R10: idle keeps vector
        step(0, 1, 0, 4'h0, 4'h8, 4'h0, "R10");
        step(0, 1, 0, 4'hF, 4'h0, 4'h0, "R10");
        // R6: release of timer latch, set wins over release, R3 release of NMI
        step(0, 0, 0, 4'h0, 4'h0, 4'h2, "R6");
        step(0, 1, 0, 4'h6, 4'h2, 4'h2, "R6");
        step(0, 1, 0, 4'h6, 4'h0, 4'h0, "R6");
        step(0, 0, 0, 4'h0, 4'h0, 4'hF, "R3");
        step(0, 1, 0, 4'h1, 4'h0, 4'h0, "R3");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0) begin
                nmi_vec = 16'($urandom); irq_vec = 16'($urandom);
            end
            step(($urandom_range(0, 199) == 0), ($urandom_range(0, 2) != 0),
                 ($urandom_range(0, 3) == 0), 4'($urandom),
                 ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'd0,
                 ($urandom_range(0, 1) == 0) ? 4'($urandom) : 4'd0, "R8");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule